// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block runs the digital side of a dual-slope integrating converter. It drives a two-bit phase select to an external analog front end and reads back a single comparator line. A conversion moves through four phases in a fixed cycle. Auto zero settles the offsets. Signal integration then runs for a programmed number of clocks. Reference deintegration follows, and a counter measures how long the integrator takes to return to zero. Integrator zero comes last and removes any charge left by overshoot.

The block records the comparator level at the end of integration as the sign. It stores the deintegration count as the magnitude and flags the new result for one clock. It can wait for a start request after each conversion, or it can run back to back in continuous mode. Two programmable limits stop a conversion from hanging when the comparator never gives the edge the block waits for: one limits deintegration, the other limits integrator zero.

Top module: `dsadc_seq`

## Requirements
- R1: After reset the phase select `ab_o` is 01 (auto zero). `valid_o`, `result_o`, `sign_o`, `ovr_o` and `iz_err_o` are all 0.
- R2: The phase select uses four codes: 01 auto zero, 10 integrate, 11 deintegrate, 00 integrator zero. It only ever changes to the next code in that cycle, 01→10→11→00→01.
- R3: Integration (`ab_o`=10) lasts exactly `int_len_i` clock cycles, and at least one.
- R4: `sign_o` takes the synchronised comparator level seen in the last integration cycle (1 = positive, 0 = negative). It changes only on the step from 10 to 11.
- R5: The comparator passes through a two-flop synchroniser. A falling edge on the synchronised signal ends deintegration. `result_o` then equals the number of cycles `ab_o` stayed at 11, minus one. `valid_o` is high for exactly one cycle, the first integrator-zero cycle.
- R6: If no falling edge arrives within `deint_max_i` cycles, deintegration lasts `deint_max_i` cycles. `result_o` is then `deint_max_i` and `ovr_o` is 1. The next edge-terminated measurement clears `ovr_o`.
- R7: Integrator zero (00) holds while the synchronised comparator is low. It moves to auto zero once the comparator is high, and `iz_err_o` stays 0.
- R8: If the comparator stays low for `iz_max_i` cycles of integrator zero, the block enters auto zero anyway. `iz_err_o` is set and stays set until the next integration begins.
- R9: Auto zero lasts at least `az_len_i` cycles, or `int_len_i` cycles when `az_len_i` is 0. With `cont_i`=1 the next integration follows that dwell at once.
- R10: With `cont_i`=0 the block stays in auto zero until `start_i` is high after the dwell. Comparator activity in auto zero changes neither the phase nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, used when not in continuous mode |
| cont_i | input | 1 | Continuous conversion mode |
| int_len_i | input | CW | Integration length in cycles |
| az_len_i | input | CW | Auto-zero dwell in cycles; 0 means the integration length is used |
| deint_max_i | input | CW | Deintegration count limit |
| iz_max_i | input | CW | Integrator-zero timeout in cycles |
| cmp_i | input | 1 | Asynchronous comparator output |
| ab_o | output | 2 | Phase select to the analog front end |
| result_o | output | CW | Magnitude of the last conversion |
| sign_o | output | 1 | Sign of the last conversion |
| valid_o | output | 1 | One-cycle pulse when a result is latched |
| ovr_o | output | 1 | Last result was clipped at the limit |
| iz_err_o | output | 1 | Integrator zero ended by timeout |

## Verification
Every cycle, the assertions check the following:
- the phase moves in a one-step cycle;
- the sign changes only when deintegration starts;
- the valid strobe lasts one cycle and comes only at the deintegrate-to-zero step;
- a latched magnitude never exceeds the limit;
- a normal exit from integrator zero follows a high comparator.

Only the bench scenarios can show the following:
- the exact phase lengths: integration, the auto-zero dwell with and without its default, and the timeout windows;
- that the magnitude equals the measured deintegration time;
- that comparator activity during auto zero is ignored;
- that the overrange and error flags are set and later cleared.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  // encoding equals the phase-select code driven to the analog front end
  typedef enum logic [1:0] {
    PH_IZERO = 2'b00,
    PH_AZERO = 2'b01,
    PH_INTEG = 2'b10,
    PH_DEINT = 2'b11
  } phase_e;
endpackage

// File: rtl/dsadc_cmp_sync.sv
module dsadc_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_i,
  output logic lvl_o,
  output logic fall_o
);
  localparam int W = STAGES + 1;

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb sh_d = {sh_q[W-2:0], cmp_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [CW-1:0] int_len_i,
  input  logic [CW-1:0] az_len_i,
  input  logic [CW-1:0] deint_max_i,
  input  logic [CW-1:0] iz_max_i,
  input  logic          cmp_lvl_i,
  input  logic          cmp_fall_i,
  output phase_e        phase_o,
  output logic [CW-1:0] res_o,
  output logic          sign_o,
  output logic          vld_o,
  output logic          ovr_o,
  output logic          iz_err_o
);
  localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_p1;
  logic [CW-1:0] az_eff;
  logic [CW-1:0] res_q, res_d;
  logic          res_en, ovr_q, ovr_d;
  logic          sign_q, sign_en;
  logic          vld_q;
  logic          izerr_q, izerr_set, izerr_clr;

  assign cnt_p1 = {1'b0, cnt_q} + ONE;
  assign az_eff = (az_len_i == '0) ? int_len_i : az_len_i;

  always_comb begin
    st_d      = st_q;
    res_en    = 1'b0;
    res_d     = res_q;
    ovr_d     = ovr_q;
    sign_en   = 1'b0;
    izerr_set = 1'b0;
    izerr_clr = 1'b0;
    unique case (st_q)
      PH_AZERO: if (go_i && cnt_p1 >= {1'b0, az_eff}) begin
        st_d      = PH_INTEG;
        izerr_clr = 1'b1;
      end
      PH_INTEG: if (cnt_p1 >= {1'b0, int_len_i}) begin
        st_d    = PH_DEINT;
        sign_en = 1'b1;
      end
      PH_DEINT: begin
        if (cmp_fall_i) begin
          st_d   = PH_IZERO;
          res_en = 1'b1;
          res_d  = cnt_q;
          ovr_d  = 1'b0;
        end else if (cnt_p1 >= {1'b0, deint_max_i}) begin
          st_d   = PH_IZERO;
          res_en = 1'b1;
          res_d  = deint_max_i;
          ovr_d  = 1'b1;
        end
      end
      PH_IZERO: begin
        if (cmp_lvl_i) begin
          st_d = PH_AZERO;
        end else if (cnt_p1 >= {1'b0, iz_max_i}) begin
          st_d      = PH_AZERO;
          izerr_set = 1'b1;
        end
      end
      default: st_d = PH_AZERO;
    endcase
    if (st_d != st_q)  cnt_d = '0;
    else if (cnt_p1[CW]) cnt_d = cnt_q;
    else               cnt_d = cnt_p1[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_AZERO;
      cnt_q   <= '0;
      res_q   <= '0;
      ovr_q   <= 1'b0;
      sign_q  <= 1'b0;
      vld_q   <= 1'b0;
      izerr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vld_q <= res_en;
      if (res_en) begin
        res_q <= res_d;
        ovr_q <= ovr_d;
      end
      if (sign_en) sign_q <= cmp_lvl_i;
      if (izerr_set)      izerr_q <= 1'b1;
      else if (izerr_clr) izerr_q <= 1'b0;
    end
  end

  assign phase_o  = st_q;
  assign res_o    = res_q;
  assign sign_o   = sign_q;
  assign vld_o    = vld_q;
  assign ovr_o    = ovr_q;
  assign iz_err_o = izerr_q;

  // R2: phase only advances one step along the cycle
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_q) |-> (2'(st_q - $past(st_q)) == 2'd1));

  // R4: sign updates only at the integrate-to-deintegrate step
  p_sign_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sign_q) |-> ($past(st_q) == PH_INTEG && st_q == PH_DEINT));

  // R5: strobe is a single cycle
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R5: strobe appears only on the first integrator-zero cycle
  p_valid_place_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (st_q == PH_IZERO && $past(st_q) == PH_DEINT));

  // R6: latched magnitude never exceeds the programmed limit
  p_result_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (res_q <= deint_max_i));

  // R7: a clean exit from integrator zero follows a high comparator
  p_iz_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PH_IZERO && st_q == PH_AZERO && !$rose(izerr_q)) |-> $past(cmp_lvl_i));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cont_i,
  input  logic [CW-1:0] int_len_i,
  input  logic [CW-1:0] az_len_i,
  input  logic [CW-1:0] deint_max_i,
  input  logic [CW-1:0] iz_max_i,
  input  logic          cmp_i,
  output logic [1:0]    ab_o,
  output logic [CW-1:0] result_o,
  output logic          sign_o,
  output logic          valid_o,
  output logic          ovr_o,
  output logic          iz_err_o
);
  logic [1:0] rsync_q;
  logic       rst_s_n;
  logic       cmp_lvl, cmp_fall;
  phase_e     phase;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  dsadc_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .cmp_i  (cmp_i),
    .lvl_o  (cmp_lvl),
    .fall_o (cmp_fall)
  );

  dsadc_phase_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .go_i        (start_i | cont_i),
    .int_len_i   (int_len_i),
    .az_len_i    (az_len_i),
    .deint_max_i (deint_max_i),
    .iz_max_i    (iz_max_i),
    .cmp_lvl_i   (cmp_lvl),
    .cmp_fall_i  (cmp_fall),
    .phase_o     (phase),
    .res_o       (result_o),
    .sign_o      (sign_o),
    .vld_o       (valid_o),
    .ovr_o       (ovr_o),
    .iz_err_o    (iz_err_o)
  );

  assign ab_o = 2'(phase);
endmodule

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, cont_i, cmp_i;
  logic [CW-1:0] int_len_i, az_len_i, deint_max_i, iz_max_i;
  logic [1:0]    ab_o;
  logic [CW-1:0] result_o;
  logic          sign_o, valid_o, ovr_o, iz_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;  // 250 MHz

  dsadc_seq #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
    .int_len_i(int_len_i), .az_len_i(az_len_i), .deint_max_i(deint_max_i),
    .iz_max_i(iz_max_i), .cmp_i(cmp_i), .ab_o(ab_o), .result_o(result_o),
    .sign_o(sign_o), .valid_o(valid_o), .ovr_o(ovr_o), .iz_err_o(iz_err_o)
  );

  // columns: integration length, cycles until comparator drops, expected sign, zero-phase delay
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{8,  5,  1, 4},
    '{12, 9,  0, 6},
    '{20, 30, 1, 3},
    '{9,  4,  0, 10},
    '{15, 17, 1, 5},
    '{10, 60, 0, 8}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog (all R) actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  // start a conversion and return the measured integration length
  task automatic start_integ(input int il, input logic sg, output int icnt);
    int g;
    int_len_i = CW'(il);
    cmp_i     = sg;
    start_i   = 1'b1;
    g = 0;
    while (ab_o != 2'b10 && g < 5000) begin tick(); g++; end
    start_i = 1'b0;
    check("R8 err cleared at integration start", int'(iz_err_o), 0);
    icnt = 0;
    while (ab_o == 2'b10 && icnt < 5000) begin icnt++; tick(); end
  endtask

  task automatic run_conv(input int il, input int d, input logic sg, input int izd);
    int icnt, dc, k;
    start_integ(il, sg, icnt);
    check("R3 integration length", icnt, il);
    cmp_i = 1'b1;
    dc = 0; k = 0;
    while (ab_o == 2'b11 && dc < 5000) begin
      dc++; tick(); k++;
      if (k == d) cmp_i = 1'b0;
    end
    check("R2 deint followed by zero phase", int'(ab_o), 0);
    check("R5 valid pulse", int'(valid_o), 1);
    check("R5 result equals deint time", int'(result_o), dc - 1);
    check("R4 sign", int'(sign_o), int'(sg));
    check("R6 overrange clear", int'(ovr_o), 0);
    tick();
    check("R5 valid one cycle", int'(valid_o), 0);
    repeat (izd) tick();
    check("R7 zero phase held while low", int'(ab_o), 0);
    cmp_i = 1'b1;
    k = 0;
    while (ab_o == 2'b00 && k < 100) begin tick(); k++; end
    check("R7 zero phase exits to auto zero", int'(ab_o), 1);
    check("R7 no error", int'(iz_err_o), 0);
  endtask

  initial begin
    int icnt, dc, k;
    rst_n = 1'b0; start_i = 1'b0; cont_i = 1'b0; cmp_i = 1'b1;
    int_len_i = 16'd8; az_len_i = 16'd0; deint_max_i = 16'd1000; iz_max_i = 16'd1000;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    check("R1 ab after reset", int'(ab_o), 1);
    check("R1 valid/result/flags after reset",
          int'({valid_o, sign_o, ovr_o, iz_err_o}) + int'(result_o), 0);

    for (int i = 0; i < NV; i++)
      run_conv(VEC[i][0], VEC[i][1], VEC[i][2][0], VEC[i][3]);

    // R6: overrange, comparator never falls
    deint_max_i = 16'd12;
    start_integ(10, 1'b1, icnt);
    check("R3 integration length", icnt, 10);
    dc = 0;
    while (ab_o == 2'b11 && dc < 5000) begin dc++; tick(); end
    check("R6 deint clipped length", dc, 12);
    check("R6 result at limit", int'(result_o), 12);
    check("R6 overrange flag", int'(ovr_o), 1);
    check("R6 valid on clip", int'(valid_o), 1);
    k = 0;
    while (ab_o != 2'b01 && k < 100) begin tick(); k++; end
    deint_max_i = 16'd1000;
    run_conv(8, 6, 1'b1, 2);  // R6: normal measurement clears overrange

    // R8: integrator-zero timeout
    iz_max_i = 16'd15;
    start_integ(8, 1'b1, icnt);
    k = 0;
    while (ab_o == 2'b11 && k < 5000) begin tick(); k++; if (k == 5) cmp_i = 1'b0; end
    dc = 0;
    while (ab_o == 2'b00 && dc < 5000) begin dc++; tick(); end
    check("R8 zero phase timeout length", dc, 15);
    check("R8 forced auto zero", int'(ab_o), 1);
    check("R8 error flag", int'(iz_err_o), 1);
    cmp_i = 1'b1;
    iz_max_i = 16'd1000;
    run_conv(8, 5, 1'b1, 3);  // checks error cleared at integration start

    // R9: continuous mode dwell, explicit and defaulted
    deint_max_i = 16'd12;
    az_len_i = 16'd7; int_len_i = 16'd8; cmp_i = 1'b1;
    cont_i = 1'b1;
    k = 0;
    while (ab_o != 2'b10 && k < 5000) begin tick(); k++; end
    k = 0;
    while (ab_o != 2'b01 && k < 5000) begin tick(); k++; end
    dc = 0;
    while (ab_o == 2'b01 && dc < 5000) begin dc++; tick(); end
    check("R9 auto zero dwell explicit", dc, 7);
    az_len_i = 16'd0; int_len_i = 16'd9;
    k = 0;
    while (ab_o != 2'b01 && k < 5000) begin tick(); k++; end
    dc = 0;
    while (ab_o == 2'b01 && dc < 5000) begin dc++; tick(); end
    check("R9 auto zero dwell defaults to integration", dc, 9);
    cont_i = 1'b0;
    k = 0;
    while (ab_o != 2'b01 && k < 5000) begin tick(); k++; end

    // R10: hold in auto zero without start, comparator toggles ignored
    repeat (30) tick();
    k = 0;
    for (int j = 0; j < 20; j++) begin
      cmp_i = ~cmp_i;
      tick();
      if (ab_o != 2'b01 || valid_o != 1'b0) k++;
    end
    check("R10 comparator ignored in auto zero", k, 0);
    check("R10 still in auto zero", int'(ab_o), 1);
    cmp_i = 1'b1;
    deint_max_i = 16'd1000;
    run_conv(11, 7, 1'b0, 4);

    summary();
    $finish;
  end
endmodule